// File: doc/BRIEF.md
# Reset Cause and Soft-Reset Control Register

This block holds a five-bit reset record in the top bits of a 32-bit register that sits in one window of a register port. The bits record why the system came out of reset (power-on, button power-on, button external reset) and carry two request bits through which software can ask for a soft power-on or a soft external reset. Software clears the cause flags by writing ones to them. Writing a one to a request bit sets it and raises a one-cycle system-reset request output.

A small saturating counter of device resets tells the first reset after power from any later one. On the first device reset, or on the first after a soft power-on request has cleared the counter, the record is loaded with only the power-on cause bit. Later device resets leave the record as it was. The counter and the record survive device resets. Only the power-up reset input clears them.

Top module: `rst_cause_reg`

## Requirements
- R1: After the power-up reset (`pwr_rst_n` low), reads of the upper word return 0x00000000, `sys_rst_req` is low and the reset counter is zero.
- R2: The register occupies bits 31:27 of the upper word, selected by address bit 2 set within the window at `WIN_BASE`. Bit 31 is the power-on cause, bit 30 the soft power-on request, bit 29 the soft external-reset request, bit 28 the button power-on cause and bit 27 the button external-reset cause. Bits 26:0 read as zero.
- R3: The lower word (address bit 2 clear) and addresses outside the window read zero, and writes to them change nothing.
- R4: Write data is first masked to bits 31:27. A one in bit 31, 28 or 27 clears that bit. A one in bit 30 or 29 sets that bit. Zeros leave bits unchanged.
- R5: A write with data bit 30 or 29 set drives `sys_rst_req` high for exactly the one cycle after the write edge. Other writes and reads leave it low.
- R6: A write with data bit 30 set clears the reset counter. A write with only bit 29 set does not clear it.
- R7: A device reset (`dev_rst_n` falling, however long it is held low) loads the register with 0x80000000 when the counter is zero, and otherwise leaves the register unchanged. Each device reset increments the counter.
- R8: The reset counter saturates at its maximum and does not wrap. Any number of device resets without a soft power-on request therefore never reloads the power-on cause.
- R9: Reads return the register value combinationally, in the same cycle as `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_rst_n | input | 1 | Power-up reset, active low, synchronous; clears everything |
| dev_rst_n | input | 1 | Device reset, active low; one event per falling level |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address on the register port |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the cycle of `rd_en` |
| sys_rst_req | output | 1 | One-cycle system-reset request |

## Verification
A write changes the register at its own clock edge, so the new value is due on the next read, one cycle later. `sys_rst_req` is due in the single cycle after the write edge, so the bench checks it high at the falling edge right after the write and low at the following falling edge. A device reset takes effect at the first edge that samples `dev_rst_n` low, and the bench reads the register only after releasing it. Read data is checked one time unit after the strobe is driven, inside the same cycle, because the read path holds no register.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;
   localparam int unsigned FIELD_W   = 5;
   localparam int unsigned FIELD_LSB = 27;
   localparam int unsigned DATA_W    = 32;
   // field index within the 5-bit record (bit 0 = register bit 27)
   localparam int unsigned IDX_PWRON   = 4;
   localparam int unsigned IDX_SW_PWR  = 3;
   localparam int unsigned IDX_SW_EXT  = 2;
   localparam int unsigned IDX_BTN_PWR = 1;
   localparam int unsigned IDX_BTN_EXT = 0;
   typedef enum logic {
      FK_CLR1 = 1'b0,
      FK_SET1 = 1'b1
   } field_kind_e;
   localparam logic [FIELD_W-1:0] SET1_MAP  = 5'b01100;
   localparam logic [FIELD_W-1:0] PWRON_VAL = 5'b10000;
endpackage

// File: rtl/rst_evt_counter.sv
module rst_evt_counter #(
   parameter int unsigned CNT_W = 4
) (
   input  logic clk,
   input  logic pwr_rst_n,
   input  logic dev_rst_n,
   input  logic clr_cnt,
   output logic evt,
   output logic first
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic             dev_q;
   logic [CNT_W-1:0] cnt_q;

   initial begin
      assert (CNT_W >= 1) else $error("CNT_W must be at least 1");
   end

   assign evt   = dev_q && !dev_rst_n;
   assign first = (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!pwr_rst_n) begin
         dev_q <= 1'b1;
         cnt_q <= '0;
      end else begin
         dev_q <= dev_rst_n;
         if (evt) begin
            if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
         end else if (clr_cnt) begin
            cnt_q <= '0;
         end
      end
   end

   assert_cnt_saturates_R8: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      (cnt_q == CNT_MAX && !clr_cnt) |=> (cnt_q == CNT_MAX));
   assert_cnt_clear_R6: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      (clr_cnt && !evt) |=> (cnt_q == '0));
endmodule

// File: rtl/rst_field_bits.sv
module rst_field_bits
   import rst_cause_pkg::*;
(
   input  logic               clk,
   input  logic               pwr_rst_n,
   input  logic               evt,
   input  logic               first,
   input  logic               wr_hit,
   input  logic [FIELD_W-1:0] wr_bits,
   output logic [FIELD_W-1:0] field
);
   for (genvar i = 0; i < FIELD_W; i++) begin : g_bit
      localparam field_kind_e KIND = field_kind_e'(SET1_MAP[i]);
      logic b_q;
      always_ff @(posedge clk) begin
         if (!pwr_rst_n) begin
            b_q <= 1'b0;
         end else if (evt) begin
            if (first) b_q <= PWRON_VAL[i];
         end else if (wr_hit && wr_bits[i]) begin
            if (KIND == FK_SET1) b_q <= 1'b1;
            else                 b_q <= 1'b0;
         end
      end
      assign field[i] = b_q;
   end

   assert_pwron_load_R7: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      (evt && first) |=> (field == PWRON_VAL));
   assert_keep_on_reset_R7: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      (evt && !first) |=> $stable(field));
   assert_req_bits_sticky_R4: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      ($fell(field[IDX_SW_PWR]) || $fell(field[IDX_SW_EXT])) |-> $past(evt));
endmodule

// File: rtl/rst_req_pulse.sv
module rst_req_pulse (
   input  logic clk,
   input  logic pwr_rst_n,
   input  logic evt,
   input  logic trig,
   output logic req
);
   always_ff @(posedge clk) begin
      if (!pwr_rst_n) req <= 1'b0;
      else            req <= trig && !evt;
   end

   assert_req_follows_R5: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      req |-> $past(trig));
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
   import rst_cause_pkg::*;
#(
   parameter int unsigned ADDR_W   = 16,
   parameter logic [15:0] WIN_BASE = 16'hF020,
   parameter int unsigned CNT_W    = 4
) (
   input  logic              clk,
   input  logic              pwr_rst_n,
   input  logic              dev_rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   output logic              sys_rst_req
);
   localparam int unsigned CMP_W = ADDR_W - 3;

   initial begin
      assert (ADDR_W >= 4 && ADDR_W <= 16) else $error("ADDR_W out of range");
   end

   logic               in_win, upper, wr_hit, evt, first, trig;
   logic [FIELD_W-1:0] wr_bits, field;

   assign in_win  = (addr[ADDR_W-1:3] == WIN_BASE[ADDR_W-1:3]);
   assign upper   = in_win && addr[2];
   assign wr_hit  = wr_en && upper;
   assign wr_bits = wdata[DATA_W-1:FIELD_LSB];
   assign trig    = wr_hit && (wr_bits[IDX_SW_PWR] || wr_bits[IDX_SW_EXT]);

   rst_evt_counter #(.CNT_W(CNT_W)) cnt_i (
      .clk(clk), .pwr_rst_n(pwr_rst_n), .dev_rst_n(dev_rst_n),
      .clr_cnt(wr_hit && wr_bits[IDX_SW_PWR]), .evt(evt), .first(first));

   rst_field_bits bits_i (
      .clk(clk), .pwr_rst_n(pwr_rst_n), .evt(evt), .first(first),
      .wr_hit(wr_hit && dev_rst_n), .wr_bits(wr_bits), .field(field));

   rst_req_pulse pulse_i (
      .clk(clk), .pwr_rst_n(pwr_rst_n), .evt(!dev_rst_n),
      .trig(trig), .req(sys_rst_req));

   assign rdata = (rd_en && upper) ? {field, {FIELD_LSB{1'b0}}} : '0;

   assert_low_bits_zero_R2: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      rdata[FIELD_LSB-1:0] == '0);
   assert_lower_word_zero_R3: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      (rd_en && !addr[2]) |-> (rdata == '0));
   assert_no_req_without_write_R5: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      sys_rst_req |-> $past(wr_en));
   logic unused_cmp;
   assign unused_cmp = (CMP_W == 0);
endmodule

// File: tb/rst_cause_reg_tb_top.sv
module rst_cause_reg_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam logic [15:0] UP = 16'hF024;
   localparam logic [15:0] LO = 16'hF020;

   logic        clk = 1'b0;
   logic        pwr_rst_n = 1'b0, dev_rst_n = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
   logic [15:0] addr = '0;
   logic [31:0] wdata = '0, rdata;
   logic        sys_rst_req;
   int          n_run = 0, n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rst_cause_reg #(.ADDR_W(16), .WIN_BASE(16'hF020), .CNT_W(2)) dut_i (
      .clk(clk), .pwr_rst_n(pwr_rst_n), .dev_rst_n(dev_rst_n), .wr_en(wr_en),
      .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
      .sys_rst_req(sys_rst_req));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd_chk(input string req, input logic [15:0] a, input logic [31:0] exp);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      #1 check(req, rdata, exp);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   // write; check pulse during the cycle after the edge, and low the next cycle
   task automatic wr(input string req, input logic [15:0] a, input logic [31:0] d,
                     input logic exp_pulse);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      check(req, {31'b0, sys_rst_req}, {31'b0, exp_pulse});
      @(negedge clk);
      check(req, {31'b0, sys_rst_req}, 32'h0);
   endtask

   task automatic dev_reset(input int hold);
      @(negedge clk);
      dev_rst_n = 1'b0;
      repeat (hold) @(negedge clk);
      dev_rst_n = 1'b1;
   endtask

   task automatic t_por_R1;
      check("R1 rdata", rdata, 32'h0);
      check("R1 req", {31'b0, sys_rst_req}, 32'h0);
      rd_chk("R1 read after power-up", UP, 32'h0);
   endtask

   task automatic t_first_reset_R7;
      dev_reset(3);
      rd_chk("R7 first reset loads power-on", UP, 32'h8000_0000);
   endtask

   task automatic t_lower_R3;
      rd_chk("R3 lower word reads zero", LO, 32'h0);
      wr("R3 lower write no pulse", LO, 32'hFFFF_FFFF, 1'b0);
      rd_chk("R3 lower write ignored", UP, 32'h8000_0000);
      wr("R3 outside window no pulse", 16'hF02C, 32'hFFFF_FFFF, 1'b0);
      rd_chk("R3 outside window ignored", UP, 32'h8000_0000);
      rd_chk("R3 outside window reads zero", 16'hF02C, 32'h0);
   endtask

   task automatic t_w1c_R4;
      wr("R4 zero write no pulse", UP, 32'h0000_0000, 1'b0);
      rd_chk("R4 zeros keep bits", UP, 32'h8000_0000);
      wr("R4 clear bit31", UP, 32'h8000_0000, 1'b0);
      rd_chk("R4 bit31 cleared", UP, 32'h0);
   endtask

   task automatic t_soft_ext_R5;
      wr("R5 soft ext pulse", UP, 32'h2000_0000, 1'b1);
      rd_chk("R4 bit29 set", UP, 32'h2000_0000);
      dev_reset(1);
      rd_chk("R6 bit29 kept counter, reset keeps reg", UP, 32'h2000_0000);
   endtask

   task automatic t_soft_pwr_R6;
      wr("R5 soft pwr pulse", UP, 32'h4000_0000, 1'b1);
      rd_chk("R4 bit30 set", UP, 32'h6000_0000);
      dev_reset(2);
      rd_chk("R6 counter cleared, reload power-on", UP, 32'h8000_0000);
   endtask

   task automatic t_mask_R2;
      wr("R5 masked write pulse", UP, 32'h7FFF_FFFF, 1'b1);
      rd_chk("R2 low bits ignored", UP, 32'hE000_0000);
      wr("R4 all-ones write", UP, 32'hFFFF_FFFF, 1'b1);
      rd_chk("R4 all-ones result", UP, 32'h6000_0000);
   endtask

   task automatic t_saturate_R8;
      dev_reset(1);
      rd_chk("R7 reload after cleared counter", UP, 32'h8000_0000);
      wr("R4 clear for saturation", UP, 32'h8000_0000, 1'b0);
      for (int i = 0; i < 6; i++) dev_reset(1);
      rd_chk("R8 no wrap to power-on", UP, 32'h0);
   endtask

   task automatic t_comb_read_R9;
      @(negedge clk);
      addr = UP; rd_en = 1'b1;
      #1 check("R9 same-cycle read", rdata, 32'h0);
      rd_en = 1'b0;
      #1 check("R9 no strobe reads zero", rdata, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      pwr_rst_n = 1'b1;
      t_por_R1();
      t_first_reset_R7();
      t_lower_R3();
      t_w1c_R4();
      t_soft_ext_R5();
      t_soft_pwr_R6();
      t_mask_R2();
      t_saturate_R8();
      t_comb_read_R9();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule